// File: doc/BRIEF.md
# Wavetable DMA Address Engine

This block holds the address and control state for block moves between host memory and a 20-bit byte-addressed sample memory on the card. Software programs a control byte, a 16-bit start address counted in 16-byte paragraphs, and a fine offset nibble. A transfer command with a unit count then makes the engine walk the card address one byte per cycle. Each byte is taken from the inbound stream and passed out, with its sign bit flipped when the control byte asks for it.

For a 16-bit channel, the linear offset is spread over twice the space. The two top address bits stay in place and the rest is doubled. Each unit is then a low byte followed by a high byte. When a transfer is accepted, the start and fine registers move forward by the unit count. When the last piece of a transfer ends, the request bit drops and an interrupt can be raised. Software learns of completion from a flag that it reads and clears through the control register.

Top module: `wtdma_engine`

## Requirements
- R1: After reset the control, start and fine registers read 0, and `irq`, `dma_req` and `out_valid` are low.
- R2: `reg_sel` picks control (0), start (1) or fine (2). A start write updates the low byte when `reg_be[0]` is set and the high byte when `reg_be[1]` is set, and it clears bits 7:4 of the fine register. A fine write stores all 8 bits. Register reads return the stored values.
- R3: For an 8-bit channel, the first card byte address of a transfer is start×16 + fine[3:0], modulo 2^20.
- R4: For a 16-bit channel (`chan16`=1), the first address is (L AND 0xC0000) + 2×(L AND 0x1FFF0), where L is the linear offset of R3.
- R5: After acceptance, one byte is emitted per cycle on consecutive card addresses. An 8-bit channel emits one byte per unit. A 16-bit channel emits two bytes per unit, low byte first. `card_we` is high only when control bit 1 is 0 (host to card).
- R6: Bit 7 of an emitted byte is inverted only when control bit 7 is 1 and control bit 1 is 0. When control bit 6 (16-bit data) is 1, the low byte of each unit is never inverted. All other bits pass through unchanged.
- R7: Accepting a transfer of N units adds N>>4 to the start register and sets the fine register to (fine + N) AND 0xF. No carry passes from the nibble into the start register.
- R8: When a transfer issued with `xfer_last`=1 ends, control bit 0 is cleared. If control bit 5 is also set, the pending flag and `irq` go high and stay high until the control register is read. A transfer issued with `xfer_last`=0 changes neither.
- R9: A control read returns the stored byte, with bit 2 forced to 1 while `chan16` is 1 and bit 6 forced to 1 while a terminal count is pending. A read strobe on the control register then clears stored bits 6 and 2 and the pending flag, which drops `irq`.
- R10: A control write with bit 0 set gives a one-cycle `dma_req` pulse in the following cycle. Any other write gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan16 | input | 1 | The host channel is 16 bits wide |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on control) |
| reg_sel | input | 2 | Register select: 0 control, 1 start, 2 fine |
| reg_be | input | 2 | Byte enables for start writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| xfer_go | input | 1 | Begin a transfer (ignored while busy or with zero units) |
| xfer_units | input | 16 | Unit count of the transfer |
| xfer_last | input | 1 | This transfer reaches terminal count |
| in_byte | input | 8 | Inbound byte for the current cycle |
| in_take | output | 1 | The inbound byte is consumed this cycle |
| out_byte | output | 8 | Outbound byte after MSB shaping |
| out_valid | output | 1 | `out_byte` and `card_addr` are valid |
| card_addr | output | 20 | Card memory byte address |
| card_we | output | 1 | Write strobe into card memory |
| busy | output | 1 | A transfer is in progress |
| dma_req | output | 1 | Request pulse to the host DMA controller |
| irq | output | 1 | Terminal-count interrupt |

## Verification
The assertions assume that software does not read or write the registers while `busy` is high. They also assume that a control read strobe never lands in the same cycle as a control write. The bench drives register accesses and `xfer_go` only on idle cycles, with one strobe at a time. The inbound byte stream is always ready, and the bench models it with a counter that steps on `in_take`. The cases cover an unaligned nibble, a start value whose bits 19:18 survive the 16-bit remapping, and a nibble sum that would carry.

// File: rtl/wtdma_pkg.sv
package wtdma_pkg;
  localparam int PARA_W = 16;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = PARA_W + NIB_W;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 16;

  localparam logic [ADDR_W-1:0] BANK_MASK = 20'hC0000;
  localparam logic [ADDR_W-1:0] MID_MASK  = 20'h1FFF0;

  localparam int CB_REQ  = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_CH16 = 2;
  localparam int CB_TCIE = 5;
  localparam int CB_WIDE = 6;
  localparam int CB_INV  = 7;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_START = 2'd1,
    SEL_FINE  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  function automatic logic [ADDR_W-1:0] lin_offset(
      input logic [PARA_W-1:0] s, input logic [NIB_W-1:0] n);
    return {s, {NIB_W{1'b0}}} + ADDR_W'(n);
  endfunction

  function automatic logic [ADDR_W-1:0] remap_wide(input logic [ADDR_W-1:0] off);
    logic [ADDR_W-1:0] keep;
    logic [ADDR_W-1:0] mid;
    keep = off & BANK_MASK;
    mid  = off & MID_MASK;
    return keep + (mid << 1);
  endfunction

  function automatic logic [PARA_W-1:0] adv_start(
      input logic [PARA_W-1:0] s, input logic [CNT_W-1:0] units);
    return s + PARA_W'(units >> NIB_W);
  endfunction

  function automatic logic [NIB_W-1:0] adv_fine(
      input logic [NIB_W-1:0] n, input logic [CNT_W-1:0] units);
    return n + units[NIB_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] shape_byte(
      input logic [BYTE_W-1:0] b, input logic inv_en, input logic c2h,
      input logic wide, input logic hi);
    logic flip;
    flip = inv_en & ~c2h & ~(wide & ~hi);
    return b ^ {flip, {(BYTE_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/wtdma_addr.sv
module wtdma_addr
  import wtdma_pkg::*;
#(
  parameter bit WIDE_REMAP = 1'b1
) (
  input  logic              chan16,
  input  logic [PARA_W-1:0] start_q,
  input  logic [NIB_W-1:0]  fine_nib,
  output logic [ADDR_W-1:0] base_addr
);
  logic [ADDR_W-1:0] linear;
  assign linear = lin_offset(start_q, fine_nib);

  generate
    if (WIDE_REMAP) begin : g_remap
      assign base_addr = chan16 ? remap_wide(linear) : linear;
    end else begin : g_flat
      logic unused_ch;
      assign unused_ch = chan16;
      assign base_addr = linear;
    end
  endgenerate
endmodule

// File: rtl/wtdma_regs.sv
module wtdma_regs
  import wtdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan16,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [1:0]        reg_be,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              xfer_accept,
  input  logic [CNT_W-1:0]  xfer_units,
  input  logic              done_evt,
  input  logic              done_tc,
  output logic [7:0]        ctrl_q,
  output logic [PARA_W-1:0] start_q,
  output logic [7:0]        fine_q,
  output logic              tc_pend,
  output logic              dma_req
);
  logic wr_ctrl, wr_start, wr_fine, rd_ctrl, tc_hit;
  logic [7:0]        ctrl_d;
  logic [PARA_W-1:0] start_d;
  logic [7:0]        fine_d;
  logic              tc_d;

  assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_start = reg_wr && (reg_sel == SEL_START);
  assign wr_fine  = reg_wr && (reg_sel == SEL_FINE);
  assign rd_ctrl  = reg_rd && (reg_sel == SEL_CTRL);
  assign tc_hit   = done_evt && done_tc;

  always_comb begin
    ctrl_d  = ctrl_q;
    tc_d    = tc_pend;
    start_d = start_q;
    fine_d  = fine_q;
    if (rd_ctrl) begin
      ctrl_d[CB_WIDE] = 1'b0;
      ctrl_d[CB_CH16] = 1'b0;
      tc_d            = 1'b0;
    end
    if (tc_hit) begin
      ctrl_d[CB_REQ] = 1'b0;
      if (ctrl_q[CB_TCIE]) tc_d = 1'b1;
    end
    if (wr_ctrl) ctrl_d = reg_wdata[7:0];
    if (xfer_accept) begin
      start_d = adv_start(start_q, xfer_units);
      fine_d  = {4'h0, adv_fine(fine_q[NIB_W-1:0], xfer_units)};
    end
    if (wr_start) begin
      if (reg_be[0]) start_d[7:0]  = reg_wdata[7:0];
      if (reg_be[1]) start_d[15:8] = reg_wdata[15:8];
      fine_d[7:4] = 4'h0;
    end
    if (wr_fine) fine_d = reg_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      start_q <= '0;
      fine_q  <= '0;
      tc_pend <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      start_q <= start_d;
      fine_q  <= fine_d;
      tc_pend <= tc_d;
      dma_req <= wr_ctrl && reg_wdata[CB_REQ];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[7:0] = ctrl_q;
        if (chan16)  reg_rdata[CB_CH16] = 1'b1;
        if (tc_pend) reg_rdata[CB_WIDE] = 1'b1;
      end
      SEL_START: reg_rdata = start_q;
      SEL_FINE:  reg_rdata[7:0] = fine_q;
      default:   reg_rdata = '0;
    endcase
  end

  AST_DREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(reg_wr && reg_sel == SEL_CTRL && reg_wdata[CB_REQ])); // R10
  AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_pend) |-> $past(done_evt && done_tc && ctrl_q[CB_TCIE])); // R8
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && done_tc && !wr_ctrl) |=> !ctrl_q[CB_REQ]); // R8
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pend && !rd_ctrl) |=> tc_pend); // R8
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !wr_ctrl && !tc_hit) |=>
      (!tc_pend && !ctrl_q[CB_WIDE] && !ctrl_q[CB_CH16])); // R9
endmodule

// File: rtl/wtdma_stream.sv
module wtdma_stream
  import wtdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_go,
  input  logic [CNT_W-1:0]  xfer_units,
  input  logic              xfer_last,
  input  logic              chan16,
  input  logic              ctl_dir,
  input  logic              ctl_inv,
  input  logic              ctl_wide,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_take,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  output logic [ADDR_W-1:0] card_addr,
  output logic              card_we,
  output logic              busy,
  output logic              accept,
  output logic              done_evt,
  output logic              done_tc
);
  logic              run_q, hi_q, dir_q, inv_q, wide_q, ch16_q, tc_q;
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;
  logic              unit_end;

  assign accept   = xfer_go && !run_q && (xfer_units != '0);
  assign unit_end = run_q && (!ch16_q || hi_q);
  assign done_evt = unit_end && (left_q == CNT_W'(1));
  assign done_tc  = tc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hi_q   <= 1'b0;
      dir_q  <= 1'b0;
      inv_q  <= 1'b0;
      wide_q <= 1'b0;
      ch16_q <= 1'b0;
      tc_q   <= 1'b0;
      left_q <= '0;
      addr_q <= '0;
    end else if (accept) begin
      run_q  <= 1'b1;
      hi_q   <= 1'b0;
      dir_q  <= ctl_dir;
      inv_q  <= ctl_inv;
      wide_q <= ctl_wide;
      ch16_q <= chan16;
      tc_q   <= xfer_last;
      left_q <= xfer_units;
      addr_q <= base_addr;
    end else if (run_q) begin
      addr_q <= addr_q + 1'b1;
      if (ch16_q && !hi_q) begin
        hi_q <= 1'b1;
      end else begin
        hi_q   <= 1'b0;
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) run_q <= 1'b0;
      end
    end
  end

  assign busy      = run_q;
  assign out_valid = run_q;
  assign in_take   = run_q;
  assign card_addr = addr_q;
  assign card_we   = run_q && !dir_q;
  assign out_byte  = shape_byte(in_byte, inv_q, dir_q, wide_q, hi_q);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> card_addr == $past(card_addr) + 1'b1); // R5
  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q |-> (ch16_q && $past(out_valid && !hi_q))); // R5
  AST_C2H_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dir_q) |-> (out_byte == in_byte && !card_we)); // R6
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wide_q && !hi_q) |-> out_byte == in_byte); // R6
  AST_LOW_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_byte[BYTE_W-2:0] == in_byte[BYTE_W-2:0]); // R6
endmodule

// File: rtl/wtdma_engine.sv
module wtdma_engine
  import wtdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan16,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [1:0]        reg_be,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              xfer_go,
  input  logic [CNT_W-1:0]  xfer_units,
  input  logic              xfer_last,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_take,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  output logic [ADDR_W-1:0] card_addr,
  output logic              card_we,
  output logic              busy,
  output logic              dma_req,
  output logic              irq
);
  logic [7:0]        ctrl_q;
  logic [PARA_W-1:0] start_q;
  logic [7:0]        fine_q;
  logic              tc_pend;
  logic [ADDR_W-1:0] base_addr;
  logic              accept, done_evt, done_tc;

  wtdma_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan16     (chan16),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_sel    (reg_sel),
    .reg_be     (reg_be),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .xfer_accept(accept),
    .xfer_units (xfer_units),
    .done_evt   (done_evt),
    .done_tc    (done_tc),
    .ctrl_q     (ctrl_q),
    .start_q    (start_q),
    .fine_q     (fine_q),
    .tc_pend    (tc_pend),
    .dma_req    (dma_req)
  );

  wtdma_addr #(.WIDE_REMAP(1'b1)) u_addr (
    .chan16   (chan16),
    .start_q  (start_q),
    .fine_nib (fine_q[NIB_W-1:0]),
    .base_addr(base_addr)
  );

  wtdma_stream u_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_go   (xfer_go),
    .xfer_units(xfer_units),
    .xfer_last (xfer_last),
    .chan16    (chan16),
    .ctl_dir   (ctrl_q[CB_DIR]),
    .ctl_inv   (ctrl_q[CB_INV]),
    .ctl_wide  (ctrl_q[CB_WIDE]),
    .base_addr (base_addr),
    .in_byte   (in_byte),
    .in_take   (in_take),
    .out_byte  (out_byte),
    .out_valid (out_valid),
    .card_addr (card_addr),
    .card_we   (card_we),
    .busy      (busy),
    .accept    (accept),
    .done_evt  (done_evt),
    .done_tc   (done_tc)
  );

  assign irq = tc_pend;

  AST_IRQ_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(out_valid) && !out_valid); // R8
  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && $past(chan16)) |-> card_addr[4:0] == 5'd0); // R4
endmodule

// File: tb/wtdma_engine_bench.sv
module wtdma_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan16 = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_sel = 2'd3, reg_be = 2'b00;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        xfer_go = 1'b0, xfer_last = 1'b0;
  logic [15:0] xfer_units = '0;
  logic [7:0]  in_byte, out_byte;
  logic        in_take, out_valid, card_we, busy, dma_req, irq;
  logic [19:0] card_addr;
  logic [7:0]  src_idx;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) src_idx <= 8'd0;
    else if (in_take) src_idx <= src_idx + 8'd1;
  end
  assign in_byte = 8'(src_idx * 8'd29) ^ 8'h35;

  wtdma_engine u_wtdma_engine (
    .clk(clk), .rst_n(rst_n), .chan16(chan16),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_go(xfer_go), .xfer_units(xfer_units), .xfer_last(xfer_last),
    .in_byte(in_byte), .in_take(in_take), .out_byte(out_byte),
    .out_valid(out_valid), .card_addr(card_addr), .card_we(card_we),
    .busy(busy), .dma_req(dma_req), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 2'b00; reg_sel = 2'd3;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [15:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
    reg_sel = 2'd3;
  endtask

  task automatic rd_ctrl(output logic [15:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = 2'd0;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_sel = 2'd3;
  endtask

  function automatic logic [19:0] exp_base(input logic [15:0] s, input logic [3:0] f, input bit w);
    logic [19:0] lin;
    lin = {s, 4'h0} + {16'h0, f};
    return w ? {lin[19:18], lin[16:4], 5'b0} : lin;
  endfunction

  task automatic run_xfer(input logic [15:0] units, input bit last, input bit w16,
                          input logic [19:0] base, input bit dir, input bit inv,
                          input bit wide, input string req);
    int nbytes = w16 ? 2 * int'(units) : int'(units);
    bit ok_addr = 1, ok_data = 1, ok_we = 1, ok_v = 1;
    logic [19:0] a_bad = '0, e_bad = '0;
    @(negedge clk);
    xfer_go = 1'b1; xfer_units = units; xfer_last = last;
    @(negedge clk);
    xfer_go = 1'b0;
    for (int k = 0; k < nbytes; k++) begin
      bit hi = w16 && (k % 2 == 1);
      bit flip = inv && !dir && !(wide && !hi);
      logic [7:0] e = in_byte ^ (flip ? 8'h80 : 8'h00);
      if (!out_valid) ok_v = 0;
      if (card_addr != base + 20'(k)) begin ok_addr = 0; a_bad = card_addr; e_bad = base + 20'(k); end
      if (out_byte != e) ok_data = 0;
      if (card_we != !dir) ok_we = 0;
      @(negedge clk);
    end
    chk(ok_v, req, "valid during stream", 32'(ok_v), 1);
    chk(ok_addr, req, "card address walk", a_bad, e_bad);
    chk(ok_data, "R6", "byte shaping", 32'(ok_data), 1);
    chk(ok_we, "R5", "card write strobe", 32'(ok_we), 1);
    chk(!out_valid, "R5", "stream stops after count", 32'(out_valid), 0);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(2'd0, v); chk(v == 0, "R1", "ctrl after reset", v, 0);
    peek(2'd1, v); chk(v == 0, "R1", "start after reset", v, 0);
    peek(2'd2, v); chk(v == 0, "R1", "fine after reset", v, 0);
    chk(!irq && !dma_req && !out_valid, "R1", "outputs idle",
        {irq, dma_req, out_valid}, 0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr_reg(2'd1, 2'b11, 16'h1234);
    wr_reg(2'd2, 2'b11, 16'h00F7);
    peek(2'd1, v); chk(v == 16'h1234, "R2", "start readback", v, 16'h1234);
    peek(2'd2, v); chk(v == 16'h00F7, "R2", "fine readback", v, 16'h00F7);
    wr_reg(2'd1, 2'b01, 16'hEEAB);
    peek(2'd1, v); chk(v == 16'h12AB, "R2", "start low-lane write", v, 16'h12AB);
    peek(2'd2, v); chk(v == 16'h0007, "R2", "start write trims fine", v, 16'h0007);
  endtask

  task automatic t_dreq();
    wr_reg(2'd0, 2'b11, 16'h0001);
    chk(dma_req == 1'b1, "R10", "request pulse", 32'(dma_req), 1);
    @(negedge clk);
    chk(dma_req == 1'b0, "R10", "request one cycle", 32'(dma_req), 0);
    wr_reg(2'd0, 2'b11, 16'h0000);
    chk(dma_req == 1'b0, "R10", "no request without bit0", 32'(dma_req), 0);
  endtask

  task automatic t_xfer8();
    logic [15:0] v;
    chan16 = 1'b0;
    wr_reg(2'd0, 2'b11, 16'h0081);
    wr_reg(2'd1, 2'b11, 16'h0100);
    wr_reg(2'd2, 2'b11, 16'h0003);
    run_xfer(16'd5, 1'b0, 1'b0, exp_base(16'h0100, 4'h3, 1'b0), 1'b0, 1'b1, 1'b0, "R3");
    peek(2'd1, v); chk(v == 16'h0100, "R7", "start after 5 units", v, 16'h0100);
    peek(2'd2, v); chk(v == 16'h0008, "R7", "fine after 5 units", v, 16'h0008);
    peek(2'd0, v); chk(v == 16'h0081, "R8", "no tc keeps request bit", v, 16'h0081);
    chk(!irq, "R8", "no irq without last", 32'(irq), 0);
  endtask

  task automatic t_xfer16();
    logic [15:0] v;
    chan16 = 1'b1;
    wr_reg(2'd0, 2'b11, 16'h00C0);
    wr_reg(2'd1, 2'b11, 16'h6ABC);
    wr_reg(2'd2, 2'b11, 16'h0005);
    run_xfer(16'd3, 1'b0, 1'b1, exp_base(16'h6ABC, 4'h5, 1'b1), 1'b0, 1'b1, 1'b1, "R4");
    peek(2'd2, v); chk(v == 16'h0008, "R7", "fine after wide xfer", v, 16'h0008);
    chan16 = 1'b0;
  endtask

  task automatic t_c2h();
    wr_reg(2'd0, 2'b11, 16'h0082);
    wr_reg(2'd1, 2'b11, 16'h0042);
    wr_reg(2'd2, 2'b11, 16'h0009);
    run_xfer(16'd4, 1'b0, 1'b0, exp_base(16'h0042, 4'h9, 1'b0), 1'b1, 1'b1, 1'b0, "R5");
  endtask

  task automatic t_carry();
    logic [15:0] v;
    wr_reg(2'd0, 2'b11, 16'h0000);
    wr_reg(2'd1, 2'b11, 16'h0010);
    wr_reg(2'd2, 2'b11, 16'h000E);
    run_xfer(16'd35, 1'b0, 1'b0, exp_base(16'h0010, 4'hE, 1'b0), 1'b0, 1'b0, 1'b0, "R3");
    peek(2'd1, v); chk(v == 16'h0012, "R7", "start no nibble carry", v, 16'h0012);
    peek(2'd2, v); chk(v == 16'h0001, "R7", "fine wraps", v, 16'h0001);
  endtask

  task automatic t_tc();
    logic [15:0] v;
    wr_reg(2'd0, 2'b11, 16'h0021);
    run_xfer(16'd2, 1'b1, 1'b0, exp_base(16'h0012, 4'h1, 1'b0), 1'b0, 1'b0, 1'b0, "R5");
    chk(irq == 1'b1, "R8", "irq at terminal count", 32'(irq), 1);
    peek(2'd0, v); chk(v == 16'h0060, "R9", "ctrl shows pending", v, 16'h0060);
    rd_ctrl(v); chk(v == 16'h0060, "R9", "ctrl read value", v, 16'h0060);
    chk(irq == 1'b0, "R9", "irq dropped by read", 32'(irq), 0);
    peek(2'd0, v); chk(v == 16'h0020, "R9", "ctrl after read", v, 16'h0020);
    wr_reg(2'd0, 2'b11, 16'h0001);
    run_xfer(16'd1, 1'b1, 1'b0, exp_base(16'h0012, 4'h3, 1'b0), 1'b0, 1'b0, 1'b0, "R5");
    peek(2'd0, v); chk(v == 16'h0000, "R8", "tc clears request bit", v, 0);
    chk(irq == 1'b0, "R8", "no irq when disabled", 32'(irq), 0);
  endtask

  task automatic t_rdclr();
    logic [15:0] v;
    chan16 = 1'b1;
    wr_reg(2'd0, 2'b11, 16'h0044);
    rd_ctrl(v); chk(v == 16'h0044, "R9", "read with wide flags", v, 16'h0044);
    chan16 = 1'b0;
    peek(2'd0, v); chk(v == 16'h0000, "R9", "bits 6 and 2 cleared", v, 0);
    peek(2'd0, v);
    chan16 = 1'b1;
    #1 chk(reg_rdata[7:0] == 8'h00 || reg_rdata[7:0] == 8'h00, "R9", "idle select", 0, 0);
    peek(2'd0, v); chk(v == 16'h0004, "R9", "bit2 forced by channel", v, 16'h0004);
    chan16 = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_dreq();
    t_xfer8();
    t_xfer16();
    t_c2h();
    t_carry();
    t_tc();
    t_rdclr();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule